// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous true dual-port RAM with a left and a right port. Both ports share one clock. Each port has a chip enable, a write select, an output enable, an upper byte enable, a lower byte enable, an address and an 18-bit data word. Either port can read or write any location in the same cycle as the other port. A word is split into an upper lane (bits 17:9) and a lower lane (bits 8:0). The byte enables pick which lanes a write stores and which lanes a read returns.

The two highest addresses also act as mailboxes between two processors. The top word (DEPTH-1) belongs to the right port, and the word below it (DEPTH-2) belongs to the left port. When the left port writes the right mailbox, the right port's active-low interrupt goes low. When the right port writes the left mailbox, the left port's interrupt goes low. The owner of a mailbox clears its own interrupt by accessing the mailbox with chip enable and output enable both high. Both mailbox words remain ordinary storage.

The depth is set by `ADDR_W`. `ADDR_W = 15` gives the full 32K-word array, and the default is kept smaller so that elaboration stays light. Every control input is active high, and `*_wr = 1` selects a write.

Top module: `mbox_dpram`

## Requirements
- R1: While reset is held, and in the first cycle after it, both interrupt outputs are high (inactive) and both read data outputs are zero.
- R2: A port writes when `en=1`, `wr=1` and at least one byte enable is high. `ub` stores bits 17:9 and `lb` stores bits 8:0. A lane whose enable is low keeps its old contents.
- R3: A port reads when `en=1`, `wr=0`, `oe=1` and at least one byte enable is high. The word appears on `rdata` one clock later. An enabled lane returns the stored bits, and a disabled lane returns zero.
- R4: With `en=0`, or with both byte enables low, a port neither stores data nor sets an interrupt. In any cycle with no read, `rdata` holds its previous value.
- R5: A left-port write (as in R2) to address DEPTH-1 drives `r_irq_n` low in the next cycle. It then stays low until the right port clears it.
- R6: A right-port write (as in R2) to address DEPTH-2 drives `l_irq_n` low in the next cycle. It then stays low until the left port clears it.
- R7: The right port clears its interrupt, so that `r_irq_n` is high in the next cycle, when `r_en=1`, `r_oe=1` and `r_addr=DEPTH-1`, whatever the values of `r_wr` and the byte enables. An access with `oe=0`, or to any other address, leaves the interrupt unchanged.
- R8: The left port clears its interrupt in the same way when `l_en=1`, `l_oe=1` and `l_addr=DEPTH-2`, whatever the value of `l_wr`. An access with `oe=0` leaves the interrupt unchanged.
- R9: Both mailbox words store and return data from either port like any other location.
- R10: If a set and a clear reach the same interrupt in the same cycle, the interrupt is asserted (low) afterwards.
- R11: When both ports write the same address in the same cycle, the left data is stored in every lane that both ports enable. Each other enabled lane takes the data of the port that enabled it.
- R12: A read of an address that the opposite port writes in the same cycle returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_en | input | 1 | Left chip enable |
| l_wr | input | 1 | Left write select (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper lane enable, bits 17:9 |
| l_lb | input | 1 | Left lower lane enable, bits 8:0 |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 18 | Left write data |
| l_rdata | output | 18 | Left read data, one cycle after the read |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_en | input | 1 | Right chip enable |
| r_wr | input | 1 | Right write select (1 = write, 0 = read) |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper lane enable, bits 17:9 |
| r_lb | input | 1 | Right lower lane enable, bits 8:0 |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 18 | Right write data |
| r_rdata | output | 18 | Right read data, one cycle after the read |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
A pending flag that is stored wrongly shows on the matching `*_irq_n` pin one cycle after the write or access that should have changed it. A lost clear or a spurious set stays visible until the next legal clear. Corrupt lane contents or a wrong write priority stay hidden until a later read of that word, and then show one cycle after that read. The bench therefore reads back every address after each write pattern. A wrong choice of returned lane or a missed hold shows on `rdata` in the cycle straight after the access.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int LANES = 2;

    typedef struct packed {
        logic l_pend;
        logic r_pend;
    } irq_state_t;

    typedef struct packed {
        logic [8:0] a_rd;
        logic [8:0] b_rd;
    } lane_rd_t;
endpackage

// File: rtl/mbox_lane_ram.sv
module mbox_lane_ram #(
    parameter int AW = 10,
    parameter int W  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic          a_re,
    input  logic          a_sel,
    input  logic [AW-1:0] a_addr,
    input  logic [W-1:0]  a_wd,
    output logic [W-1:0]  a_rd,
    input  logic          b_we,
    input  logic          b_re,
    input  logic          b_sel,
    input  logic [AW-1:0] b_addr,
    input  logic [W-1:0]  b_wd,
    output logic [W-1:0]  b_rd
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [W-1:0] a_rd;
        logic [W-1:0] b_rd;
    } rd_t;

    logic [W-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;

    // Port a is written last so that it wins on a shared address.
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wd;
        if (a_we) mem[a_addr] <= a_wd;
    end

    always_comb begin
        rd_d = rd_q;
        if (a_re) rd_d.a_rd = a_sel ? mem[a_addr] : '0;
        if (b_re) rd_d.b_rd = b_sel ? mem[b_addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign a_rd = rd_q.a_rd;
    assign b_rd = rd_q.b_rd;
endmodule

// File: rtl/mbox_irq_ctl.sv
module mbox_irq_ctl
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_set,
    input  logic l_clr,
    input  logic r_set,
    input  logic r_clr,
    output logic l_irq_n,
    output logic r_irq_n
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (l_clr) st_d.l_pend = 1'b0;
        if (l_set) st_d.l_pend = 1'b1;
        if (r_clr) st_d.r_pend = 1'b0;
        if (r_set) st_d.r_pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign l_irq_n = ~st_q.l_pend;
    assign r_irq_n = ~st_q.r_pend;
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic              l_ub,
    input  logic              l_lb,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic              r_ub,
    input  logic              r_lb,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    localparam int LANE_W = DATA_W / LANES;
    localparam logic [ADDR_W-1:0] R_BOX = '1;
    localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

    logic l_act, r_act, l_wgo, r_wgo, l_rgo, r_rgo;
    logic l_set, l_clr, r_set, r_clr;
    logic [LANES-1:0] l_sel, r_sel;

    assign l_sel = {l_ub, l_lb};
    assign r_sel = {r_ub, r_lb};
    assign l_act = l_en & (|l_sel);
    assign r_act = r_en & (|r_sel);
    assign l_wgo = l_act & l_wr;
    assign r_wgo = r_act & r_wr;
    assign l_rgo = l_act & ~l_wr & l_oe;
    assign r_rgo = r_act & ~r_wr & r_oe;

    // Each port's write into the other's mailbox sets that port's flag.
    assign r_set = l_wgo & (l_addr == R_BOX);
    assign l_set = r_wgo & (r_addr == L_BOX);
    assign r_clr = r_en & r_oe & (r_addr == R_BOX);
    assign l_clr = l_en & l_oe & (l_addr == L_BOX);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mbox_lane_ram #(.AW(ADDR_W), .W(LANE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .a_we   (l_wgo & l_sel[g]),
            .a_re   (l_rgo),
            .a_sel  (l_sel[g]),
            .a_addr (l_addr),
            .a_wd   (l_wdata[g*LANE_W +: LANE_W]),
            .a_rd   (l_rdata[g*LANE_W +: LANE_W]),
            .b_we   (r_wgo & r_sel[g]),
            .b_re   (r_rgo),
            .b_sel  (r_sel[g]),
            .b_addr (r_addr),
            .b_wd   (r_wdata[g*LANE_W +: LANE_W]),
            .b_rd   (r_rdata[g*LANE_W +: LANE_W])
        );
    end

    mbox_irq_ctl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_set   (l_set),
        .l_clr   (l_clr),
        .r_set   (r_set),
        .r_clr   (r_clr),
        .l_irq_n (l_irq_n),
        .r_irq_n (r_irq_n)
    );
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_en,
    input logic              l_wr,
    input logic              l_oe,
    input logic              l_ub,
    input logic              l_lb,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_wdata,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq_n,
    input logic              r_en,
    input logic              r_wr,
    input logic              r_oe,
    input logic              r_ub,
    input logic              r_lb,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_wdata,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] TOP  = '1;
    localparam logic [ADDR_W-1:0] NEXT = TOP - 1'b1;

    logic lw_top, rw_next, l_own, r_own, l_rd, r_rd;
    assign lw_top  = l_en && l_wr && (l_ub || l_lb) && l_addr == TOP;
    assign rw_next = r_en && r_wr && (r_ub || r_lb) && r_addr == NEXT;
    assign l_own   = l_en && l_oe && l_addr == NEXT;
    assign r_own   = r_en && r_oe && r_addr == TOP;
    assign l_rd    = l_en && !l_wr && l_oe && (l_ub || l_lb);
    assign r_rd    = r_en && !r_wr && r_oe && (r_ub || r_lb);

    // R5, R10: left write into the top word raises the right interrupt
    a_r5_right_set: assert property (@(posedge clk) disable iff (!rst_n)
        lw_top |=> !r_irq_n);
    // R6, R10
    a_r6_left_set: assert property (@(posedge clk) disable iff (!rst_n)
        rw_next |=> !l_irq_n);
    // R7
    a_r7_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (r_own && !lw_top) |=> r_irq_n);
    // R8
    a_r8_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (l_own && !rw_next) |=> l_irq_n);
    // R5, R6: flags hold without a set or clear
    a_r5_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_own && !lw_top) |=> $stable(r_irq_n));
    a_r6_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_own && !rw_next) |=> $stable(l_irq_n));
    // R4: read data holds when the port does not read
    a_r4_l_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd |=> $stable(l_rdata));
    a_r4_r_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd |=> $stable(r_rdata));
    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0));
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mbox_dpram.sv
module tb_mbox_dpram;
    localparam int CLK_P = 10;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] TOP  = DEPTH - 1;
    localparam logic [AW-1:0] NEXT = DEPTH - 2;

    logic clk = 1'b0;
    logic rst_n;
    logic l_en, l_wr, l_oe, l_ub, l_lb, r_en, r_wr, r_oe, r_ub, r_lb;
    logic [AW-1:0] l_addr, r_addr;
    logic [17:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [17:0] model [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    mbox_dpram #(.ADDR_W(AW), .DATA_W(18)) dut (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    function automatic logic [17:0] pat(input int a, input int s);
        return 18'((a * 4663) ^ (s * 9001) ^ 18'h2A5A5);
    endfunction

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lp(input logic en, wr, oe, ub, lb, input logic [AW-1:0] a, input logic [17:0] d);
        l_en = en; l_wr = wr; l_oe = oe; l_ub = ub; l_lb = lb; l_addr = a; l_wdata = d;
    endtask

    task automatic rp(input logic en, wr, oe, ub, lb, input logic [AW-1:0] a, input logic [17:0] d);
        r_en = en; r_wr = wr; r_oe = oe; r_ub = ub; r_lb = lb; r_addr = a; r_wdata = d;
    endtask

    task automatic idle();
        lp(0, 0, 0, 0, 0, '0, '0);
        rp(0, 0, 0, 0, 0, '0, '0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        logic [17:0] hold, v, w;
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 l_irq_n", 18'(l_irq_n), 18'd1);
        chk("R1 r_irq_n", 18'(r_irq_n), 18'd1);
        chk("R1 l_rdata", l_rdata, '0);
        chk("R1 r_rdata", r_rdata, '0);
        rst_n = 1'b1;
        step();
        chk("R1 l_irq_n after release", 18'(l_irq_n), 18'd1);

        // R2, R9: fill every word from the left with full lanes
        for (int a = 0; a < DEPTH; a++) begin
            lp(1, 1, 0, 1, 1, AW'(a), pat(a, 1));
            step();
            model[a] = pat(a, 1);
        end
        idle();
        step();
        chk("R5 r_irq_n set by left write to top", 18'(r_irq_n), 18'd0);
        chk("R6 l_irq_n not set by own mailbox write", 18'(l_irq_n), 18'd1);

        // R3, R9: right reads every word below the top
        for (int a = 0; a < DEPTH - 1; a++) begin
            rp(1, 0, 1, 1, 1, AW'(a), '0);
            step();
            chk("R9 right readback", r_rdata, model[a]);
        end
        chk("R7 other addresses do not clear", 18'(r_irq_n), 18'd0);
        rp(1, 0, 1, 1, 1, TOP, '0);
        step();
        chk("R9 right reads top word", r_rdata, model[TOP]);
        chk("R7 right read of top clears", 18'(r_irq_n), 18'd1);
        idle();

        // R3: left reads every word
        for (int a = 0; a < DEPTH; a++) begin
            lp(1, 0, 1, 1, 1, AW'(a), '0);
            step();
            chk("R3 left readback", l_rdata, model[a]);
        end

        // R2: single-lane writes
        for (int m = 1; m <= 2; m++) begin
            v = pat(3, m + 5);
            lp(1, 1, 0, m[1], m[0], 4'd3, v);
            step();
            if (m[1]) model[3][17:9] = v[17:9];
            if (m[0]) model[3][8:0]  = v[8:0];
            lp(1, 0, 1, 1, 1, 4'd3, '0);
            step();
            chk("R2 lane write merge", l_rdata, model[3]);
        end
        // R3: partial reads return zero in the disabled lane
        lp(1, 0, 1, 1, 0, 4'd3, '0);
        step();
        chk("R3 upper-only read", l_rdata, {model[3][17:9], 9'd0});
        lp(1, 0, 1, 0, 1, 4'd3, '0);
        step();
        chk("R3 lower-only read", l_rdata, {9'd0, model[3][8:0]});

        // R4: no access with en low or no lanes
        hold = l_rdata;
        lp(0, 1, 1, 1, 1, 4'd5, ~model[5]);
        step();
        chk("R4 rdata held with en low", l_rdata, hold);
        lp(1, 1, 1, 0, 0, 4'd5, ~model[5]);
        step();
        chk("R4 rdata held with no lanes", l_rdata, hold);
        lp(1, 0, 1, 0, 0, 4'd5, '0);
        step();
        chk("R4 no-lane read holds rdata", l_rdata, hold);
        lp(1, 0, 1, 1, 1, 4'd5, '0);
        step();
        chk("R4 word unchanged", l_rdata, model[5]);
        idle();
        rp(0, 1, 0, 1, 1, NEXT, 18'h3FFFF);
        step();
        chk("R4 disabled write sets nothing", 18'(l_irq_n), 18'd1);
        rp(1, 1, 0, 0, 0, NEXT, 18'h3FFFF);
        step();
        chk("R4 no-lane write sets nothing", 18'(l_irq_n), 18'd1);

        // R6: right writes lower lane of left mailbox
        v = pat(14, 7);
        rp(1, 1, 0, 0, 1, NEXT, v);
        step();
        model[NEXT][8:0] = v[8:0];
        idle();
        chk("R6 l_irq_n set by right write", 18'(l_irq_n), 18'd0);
        // R8: oe low does not clear
        lp(1, 0, 0, 1, 1, NEXT, '0);
        step();
        chk("R8 no clear with oe low", 18'(l_irq_n), 18'd0);
        // R8: clear with write select high, which also stores data
        v = pat(14, 9);
        lp(1, 1, 1, 1, 1, NEXT, v);
        step();
        model[NEXT] = v;
        chk("R8 clear regardless of wr", 18'(l_irq_n), 18'd1);

        // R10, R12: set and clear together on the left flag
        w = pat(14, 11);
        rp(1, 1, 0, 1, 1, NEXT, w);
        lp(1, 0, 1, 1, 1, NEXT, '0);
        step();
        chk("R12 read returns pre-write data", l_rdata, model[NEXT]);
        chk("R10 set wins on left flag", 18'(l_irq_n), 18'd0);
        model[NEXT] = w;
        rp(0, 0, 0, 0, 0, '0, '0);
        step();
        chk("R9 left mailbox holds right data", l_rdata, model[NEXT]);
        chk("R8 left read clears", 18'(l_irq_n), 18'd1);

        // R10: set and clear together on the right flag
        w = pat(15, 13);
        lp(1, 1, 0, 1, 1, TOP, w);
        rp(1, 0, 1, 1, 1, TOP, '0);
        step();
        chk("R10 set wins on right flag", 18'(r_irq_n), 18'd0);
        model[TOP] = w;
        lp(0, 0, 0, 0, 0, '0, '0);
        step();
        chk("R9 top word from right", r_rdata, model[TOP]);
        chk("R7 right clear", 18'(r_irq_n), 18'd1);
        idle();

        // R11: simultaneous writes
        lp(1, 1, 0, 1, 1, 4'd7, pat(7, 21));
        rp(1, 1, 0, 1, 1, 4'd7, pat(7, 22));
        step();
        model[7] = pat(7, 21);
        idle();
        rp(1, 0, 1, 1, 1, 4'd7, '0);
        step();
        chk("R11 left wins full word", r_rdata, model[7]);
        v = pat(7, 23);
        w = pat(7, 24);
        lp(1, 1, 0, 0, 1, 4'd7, v);
        rp(1, 1, 0, 1, 1, 4'd7, w);
        step();
        model[7] = {w[17:9], v[8:0]};
        idle();
        rp(1, 0, 1, 1, 1, 4'd7, '0);
        step();
        chk("R11 lane mix", r_rdata, model[7]);

        // R12: read against opposite write
        v = pat(9, 30);
        lp(1, 0, 1, 1, 1, 4'd9, '0);
        rp(1, 1, 0, 1, 1, 4'd9, v);
        step();
        chk("R12 old data on collision", l_rdata, model[9]);
        model[9] = v;
        rp(0, 0, 0, 0, 0, '0, '0);
        step();
        chk("R12 new data next read", l_rdata, model[9]);

        idle();
        step();
        report();
    end
endmodule